// File: doc/BRIEF.md
# Programmable Interval Timer

This peripheral holds a 32-bit counter that counts down. Software reaches it through a 16-bit synchronous register port. Software loads a period in two 16-bit halves. It then starts the counter and picks one of two modes. In continuous mode the counter reloads and keeps running after each timeout. In one-shot mode it halts after the first timeout. Each timeout sets a sticky flag. The flag drives a level interrupt when the interrupt enable bit is set, and any write to the status word clears it.

The counter keeps running while software reads it. A write to the low snapshot word copies the whole 32-bit count into a holding register in one step. Software then reads the two snapshot halves at its own pace, and the two halves always come from the same instant. Start and stop are one-cycle strobe bits in the control word and are never stored. Writing either period half always stops the counter and loads it with the new full period.

Top module: `ivl_timer`

## Requirements
- R1: After reset the counter is stopped, both period halves read 0xFFFF, the control word reads 0, the status word reads 0 and irq is low.
- R2: The word addresses are 0 status, 1 control, 2 period bits 15:0, 3 period bits 31:16, 4 snapshot bits 15:0 and 5 snapshot bits 31:16. Status bit 0 is the timeout flag and status bit 1 shows that the counter is running. Control bit 0 is the interrupt enable, bit 1 is continuous mode, bit 2 is the start strobe and bit 3 is the stop strobe. The period halves read back as written, and the control word reads back only bits 0 and 1.
- R3: With period value P, the timeout flag sets exactly P+1 clock cycles after the write that starts the counter.
- R4: In continuous mode the counter reloads P at each timeout and keeps running, so consecutive timeouts lie P+1 cycles apart.
- R5: In one-shot mode the counter stops at the timeout, status bit 1 reads 0 afterwards, and the count holds the reloaded value P.
- R6: A control write with bit 2 set starts a stopped counter. A control write with bit 3 set stops it, and the count then holds its value. When bits 2 and 3 are written together, the stop wins.
- R7: A write to either period half stops the counter and loads the full new 32-bit period into the count.
- R8: Any write to address 4 latches the current 32-bit count. Reads of addresses 4 and 5 then return that value unchanged until the next such write.
- R9: Any write to address 0 clears the timeout flag. If a timeout falls in the same cycle as the clear, the flag stays set.
- R10: irq is high exactly when the timeout flag is set and control bit 0 is 1. It is a level that follows both terms.
- R11: Once set, the timeout flag stays set until a status write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 16 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; bus_rdata is zero when it is low |
| bus_rdata | output | 16 | Read data, combinational from the address |
| irq | output | 1 | Timeout interrupt level |

## Verification
Some behaviours hold from one cycle to the next, and the embedded assertions check them on every cycle. These are the one-step decrement and the reload at zero, the one-shot halt, a stop and a period load taking effect on the next cycle, the sticky flag and a snapshot that holds between latch writes. Other properties only show up over whole sequences, and only the bench scenarios can show them. These are the exact P+1 spacing of timeouts measured at the pins across a sweep of small periods, the register readback map, the coherence of the two snapshot halves, the outcome of a clear that lands on a timeout cycle, and the interrupt gating when the enable bit changes after the flag is already set.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
   localparam int A_STAT  = 0;
   localparam int A_CTRL  = 1;
   localparam int A_PERLO = 2;
   localparam int A_SNPLO = 4;
   localparam int NHALF   = 2;

   localparam int CB_IEN  = 0;
   localparam int CB_CONT = 1;
   localparam int CB_GO   = 2;
   localparam int CB_HALT = 3;

   localparam int SB_FLAG = 0;
   localparam int SB_RUN  = 1;

   typedef struct packed {
      logic cont;
      logic ien;
   } ctl_t;
endpackage

// File: rtl/ivl_timer_core.sv
module ivl_timer_core #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] period,
   input  logic [CNT_W-1:0] load_val,
   input  logic             load,
   input  logic             cont,
   input  logic             go,
   input  logic             halt,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt,
   output logic             running,
   output logic             flag
);
   logic tick;
   logic at_zero;

   assign tick    = running && !halt && !load;
   assign at_zero = (cnt == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt     <= '1;
         running <= 1'b0;
         flag    <= 1'b0;
      end else begin
         if (load)
            cnt <= load_val;
         else if (tick)
            cnt <= at_zero ? period : cnt - 1'b1;

         if (load || halt)
            running <= 1'b0;
         else if (go)
            running <= 1'b1;
         else if (tick && at_zero && !cont)
            running <= 1'b0;

         if (tick && at_zero)
            flag <= 1'b1;
         else if (clr)
            flag <= 1'b0;
      end
   end

   AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !at_zero) |=> (cnt == $past(cnt) - 1'b1)); // R3
   AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && at_zero) |=> (flag && cnt == $past(period))); // R4
   AST_ONESHOT_HALT: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && at_zero && !cont && !go) |=> !running); // R5
   AST_STOP_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> (!running && cnt == $past(cnt))); // R6
   AST_LOAD_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (!running && cnt == $past(load_val))); // R7
   AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag); // R11
endmodule

// File: rtl/ivl_timer_regs.sv
module ivl_timer_regs
   import ivl_timer_pkg::*;
#(
   parameter int BUS_W  = 16,
   parameter int CNT_W  = 32,
   parameter int ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  wdata,
   input  logic              wr,
   input  logic              rd,
   input  logic [CNT_W-1:0]  cnt,
   input  logic              running,
   input  logic              flag,
   output logic [CNT_W-1:0]  period,
   output logic [CNT_W-1:0]  per_nx,
   output logic              per_load,
   output logic              go,
   output logic              halt,
   output logic              clr,
   output ctl_t              ctl,
   output logic [BUS_W-1:0]  rdata
);
   generate
      if (CNT_W != NHALF * BUS_W) begin : g_bad_width
         $error("ivl_timer_regs: CNT_W must be twice BUS_W");
      end
      if (BUS_W < 4) begin : g_bad_bus
         $error("ivl_timer_regs: BUS_W must hold the control bits");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("ivl_timer_regs: ADDR_W must reach six words");
      end
   endgenerate

   logic             ctl_wr;
   logic             snap_wr;
   logic [NHALF-1:0] per_hit;
   logic [CNT_W-1:0] snap_q;

   assign ctl_wr   = wr && (addr == ADDR_W'(A_CTRL));
   assign snap_wr  = wr && (addr == ADDR_W'(A_SNPLO));
   assign clr      = wr && (addr == ADDR_W'(A_STAT));
   assign go       = ctl_wr && wdata[CB_GO];
   assign halt     = ctl_wr && wdata[CB_HALT];
   assign per_load = |per_hit;

   for (genvar h = 0; h < NHALF; h++) begin : g_half
      assign per_hit[h] = wr && (addr == ADDR_W'(A_PERLO + h));
      assign per_nx[h*BUS_W +: BUS_W] = per_hit[h] ? wdata : period[h*BUS_W +: BUS_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         period <= '1;
         ctl    <= '0;
         snap_q <= '0;
      end else begin
         period <= per_nx;
         if (ctl_wr) begin
            ctl.ien  <= wdata[CB_IEN];
            ctl.cont <= wdata[CB_CONT];
         end
         if (snap_wr)
            snap_q <= cnt;
      end
   end

   always_comb begin
      rdata = '0;
      if (rd) begin
         if (addr == ADDR_W'(A_STAT)) begin
            rdata[SB_FLAG] = flag;
            rdata[SB_RUN]  = running;
         end else if (addr == ADDR_W'(A_CTRL)) begin
            rdata[CB_IEN]  = ctl.ien;
            rdata[CB_CONT] = ctl.cont;
         end
         for (int h = 0; h < NHALF; h++) begin
            if (addr == ADDR_W'(A_PERLO + h))
               rdata = period[h*BUS_W +: BUS_W];
            if (addr == ADDR_W'(A_SNPLO + h))
               rdata = snap_q[h*BUS_W +: BUS_W];
         end
      end
   end

   AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !snap_wr |=> $stable(snap_q)); // R8
   AST_SNAP_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
      snap_wr |=> (snap_q == $past(cnt))); // R8
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
   import ivl_timer_pkg::*;
#(
   parameter int BUS_W  = 16,
   parameter int ADDR_W = 3,
   localparam int CNT_W = NHALF * BUS_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   input  logic              bus_wr,
   input  logic              bus_rd,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq
);
   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] per_nx;
   logic [CNT_W-1:0] cnt;
   logic             per_load, go, halt, clr, running, flag;
   ctl_t             ctl;

   ivl_timer_regs #(.BUS_W(BUS_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
      .wr(bus_wr), .rd(bus_rd), .cnt(cnt), .running(running), .flag(flag),
      .period(period), .per_nx(per_nx), .per_load(per_load), .go(go),
      .halt(halt), .clr(clr), .ctl(ctl), .rdata(bus_rdata)
   );

   ivl_timer_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .period(period), .load_val(per_nx),
      .load(per_load), .cont(ctl.cont), .go(go), .halt(halt), .clr(clr),
      .cnt(cnt), .running(running), .flag(flag)
   );

   assign irq = flag & ctl.ien;

   AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(A_STAT) && !running) |=> !irq); // R9
endmodule

// File: tb/sim_ivl_timer.sv
`timescale 1ns/1ps
module sim_ivl_timer;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   ivl_timer u0 (.clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
                 .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_rd = 1'b1; bus_addr = a;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic wait_irq(output int n);
      n = 0;
      while (!irq && n < 1000) begin
         @(posedge clk);
         #1 n++;
      end
   endtask

   task automatic set_period(input logic [31:0] p);
      wr(3'd2, p[15:0]);
      wr(3'd3, p[31:16]);
   endtask

   task automatic read_snap(output logic [31:0] v);
      logic [15:0] lo, hi;
      rd(3'd4, lo);
      rd(3'd5, hi);
      v = {hi, lo};
   endtask

   initial begin
      logic [15:0] d;
      logic [31:0] s1, s2;
      int n;

      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd(3'd0, d); chk("R1 status", d, 0);
      rd(3'd1, d); chk("R1 control", d, 0);
      rd(3'd2, d); chk("R1 period lo", d, 16'hFFFF);
      rd(3'd3, d); chk("R1 period hi", d, 16'hFFFF);
      chk("R1 irq", irq, 0);

      // R2 register readback
      wr(3'd2, 16'h1234); wr(3'd3, 16'hABCD);
      rd(3'd2, d); chk("R2 period lo", d, 16'h1234);
      rd(3'd3, d); chk("R2 period hi", d, 16'hABCD);
      wr(3'd1, 16'h0003);
      rd(3'd1, d); chk("R2 control", d, 16'h0003);
      rd(3'd0, d); chk("R2 not running", d, 0);

      // R6 stop wins when both strobes written
      wr(3'd1, 16'h000F);
      rd(3'd0, d); chk("R6 both strobes", d, 0);
      rd(3'd1, d); chk("R6 strobes read 0", d, 16'h0003);
      wr(3'd1, 16'h0000);

      // R3 / R5 one-shot sweep
      for (int p = 0; p < 8; p++) begin
         set_period(32'(p));
         wr(3'd1, 16'h0005);
         wait_irq(n);
         chk("R3 timeout delay", 32'(n), 32'(p + 1));
         rd(3'd0, d); chk("R5 one-shot stopped", d, 16'h0001);
         wr(3'd4, 16'h0);
         read_snap(s1); chk("R5 count holds P", s1, 32'(p));
         wr(3'd0, 16'h0);
         rd(3'd0, d); chk("R9 clear flag", d, 0);
         chk("R9 irq low", irq, 0);
      end

      // R4 continuous sweep
      for (int p = 1; p < 7; p++) begin
         set_period(32'(p));
         wr(3'd1, 16'h0007);
         wait_irq(n);
         chk("R4 first interval", 32'(n), 32'(p + 1));
         wr(3'd0, 16'h0);
         wait_irq(n);
         chk("R4 reload interval", 32'(n + 1), 32'(p + 1));
         rd(3'd0, d); chk("R4 still running", d, 16'h0003);
         wr(3'd1, 16'h000B);
         rd(3'd0, d); chk("R6 stop", d[1], 0);
         wr(3'd0, 16'h0);
      end

      // R9 clear coinciding with timeout: P=0 continuous
      set_period(32'd0);
      wr(3'd1, 16'h0007);
      wait_irq(n);
      wr(3'd0, 16'h0);
      chk("R9 set beats clear", irq, 1);
      wr(3'd1, 16'h000B);
      wr(3'd0, 16'h0);
      chk("R9 cleared when stopped", irq, 0);

      // R10 / R11 interrupt gating and sticky flag
      set_period(32'd3);
      wr(3'd1, 16'h0004);
      repeat (10) @(posedge clk);
      #1 chk("R10 irq masked", irq, 0);
      rd(3'd0, d); chk("R11 flag held", d, 16'h0001);
      wr(3'd1, 16'h0001);
      #1 chk("R10 irq on enable", irq, 1);
      wr(3'd1, 16'h0000);
      #1 chk("R10 irq off on disable", irq, 0);
      wr(3'd1, 16'h0001);
      wr(3'd0, 16'h0);
      #1 chk("R10 irq off on clear", irq, 0);

      // R8 coherent snapshot across halves
      wr(3'd2, 16'h0003); wr(3'd3, 16'h0001);
      wr(3'd1, 16'h0004);
      wr(3'd4, 16'h0);
      read_snap(s1); chk("R8 snapshot value", s1, 32'h0001_0003);
      repeat (20) @(posedge clk);
      read_snap(s2); chk("R8 snapshot stable", s2, 32'h0001_0003);

      // R7 period write stops and loads
      wr(3'd2, 16'h0050);
      rd(3'd0, d); chk("R7 stopped", d[1], 0);
      wr(3'd4, 16'h0);
      read_snap(s1); chk("R7 loaded", s1, 32'h0001_0050);

      // R6 start then stop holds count
      wr(3'd1, 16'h0004);
      rd(3'd0, d); chk("R6 start", d[1], 1);
      wr(3'd1, 16'h0008);
      wr(3'd4, 16'h0);
      read_snap(s1);
      repeat (10) @(posedge clk);
      wr(3'd4, 16'h0);
      read_snap(s2);
      chk("R6 stopped count holds", s2, s1);
      chk("R6 count moved while running", 32'(s1 != 32'h0001_0050), 1);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule